// File: doc/BRIEF.md
# Data-Processing Operand and ALU Stage

This block is the combinational execute step for a small group of 32-bit data-processing instructions. It receives the instruction word and the two source register values. The register file sits outside the block and supplies both values. From these the block forms a result, a destination register index and a write enable. No clock is involved. The outputs follow the inputs within the same cycle.

The second operand comes from one of two places, chosen by a single instruction bit. The first source is the register value. The second is an immediate built from the instruction itself: an 8-bit constant is zero-extended and then rotated right by an even amount of 0 to 30 bit positions. The block performs four operations:

- a copy of the second operand;
- a bitwise AND;
- a subtraction;
- a reversed subtraction, which makes it possible to take a register away from an immediate.

For any instruction outside this group, the write enable stays low.

Top module: `dp_exec_stage`

## Requirements
- R1: The write enable is high only when instruction bits 27:26 equal 00. Any other class code gives a low write enable.
- R2: Instruction bits 24:21 select the operation: 1101 copy, 0000 AND, 0010 subtract, 0011 reverse subtract. Any other code in the data-processing class gives a low write enable.
- R3: Instruction bit 25 picks the second operand. A 1 selects the expanded immediate. A 0 selects the register value `rm_val_i`.
- R4: The expanded immediate is instruction bits 7:0, zero-extended to 32 bits and rotated right by twice the unsigned value of bits 11:8. Bits that leave the low end come back in at the high end.
- R5: A rotate field of 0 gives the zero-extended byte unchanged. A rotate field of 15 rotates right by 30, so the byte moves up by two places with wrap.
- R6: The copy operation returns the second operand, and `rn_val_i` has no effect on its result.
- R7: The AND operation returns `rn_val_i` bitwise-ANDed with the second operand.
- R8: The subtract operation returns `rn_val_i` minus the second operand, modulo 2^32. Wrap-around is not flagged.
- R9: The reverse subtract operation returns the second operand minus `rn_val_i`, modulo 2^32.
- R10: The destination index output equals instruction bits 15:12, whatever the operation.
- R11: Instruction bit 20 has no effect on the result or on the write enable.
- R12: When the write enable is low, the result output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word being executed |
| rn_val_i | input | 32 | First source register value |
| rm_val_i | input | 32 | Second source register value |
| result_o | output | 32 | Computed result, zero when not writing |
| rd_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Result is to be written to the destination |

## Verification
The stage has no storage, so any fault in the rotator, the operand mux or the operation decode shows up on `result_o` or `wr_en_o` as soon as the inputs settle. It is visible in the very cycle the instruction is applied.

- A wrong stage in the rotator corrupts only those immediates whose rotate field has the matching bit set. For that reason the checks sweep all sixteen rotate values against a rotation that the bench computes one bit at a time.
- A swapped mux or swapped operands in the subtractor turns the result into the negated value, which is easy to tell apart from the expected one.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;
  localparam int INSTR_W   = 32;
  localparam int DATA_W    = 32;
  localparam int REG_IDX_W = 4;
  localparam int IMM_VAL_W = 8;
  localparam int ROT_W     = 4;
  localparam int OPC_W     = 4;

  // bit positions that the operation decode depends on
  localparam int CLASS_LO  = 26;
  localparam int IMMSEL_B  = 25;
  localparam int OPC_LO    = 21;
  localparam int RN_LO     = 16;
  localparam int RD_LO     = 12;
  localparam int ROT_LO    = 8;

  typedef enum logic [OPC_W-1:0] {
    OPC_AND  = 4'b0000,
    OPC_SUB  = 4'b0010,
    OPC_RSB  = 4'b0011,
    OPC_COPY = 4'b1101
  } dp_opc_e;

  typedef struct packed {
    logic                 valid;
    dp_opc_e              opc;
    logic                 use_imm;
    logic [REG_IDX_W-1:0] rd;
    logic [ROT_W-1:0]     rot;
    logic [IMM_VAL_W-1:0] imm_val;
  } dp_ctrl_t;

  function automatic logic [DATA_W-1:0] alu_eval(dp_opc_e opc,
                                                 logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b);
    case (opc)
      OPC_AND:  return a & b;
      OPC_SUB:  return a - b;
      OPC_RSB:  return b - a;
      OPC_COPY: return b;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/dp_imm_expand.sv
module dp_imm_expand
  import dp_exec_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int VAL_W = IMM_VAL_W,
  parameter int RW    = ROT_W
) (
  input  logic [VAL_W-1:0] val_i,
  input  logic [RW-1:0]    rot_i,
  output logic [W-1:0]     imm_o
);
  // log-depth rotator: stage k rotates right by 2^(k+1) when rot_i[k] is set
  logic [W-1:0] stage [RW+1];
  assign stage[0] = {{(W-VAL_W){1'b0}}, val_i};

  for (genvar k = 0; k < RW; k++) begin : g_rot
    localparam int SH = 2 << k;
    assign stage[k+1] = rot_i[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
  end

  assign imm_o = stage[RW];

  always_comb begin
    assert_rot_zero_passthru_R5: assert (rot_i != '0 || imm_o == stage[0])
      else $error("R5: rotate 0 altered immediate");
    assert_bitcount_kept_R4: assert ($countones(imm_o) == $countones(val_i))
      else $error("R4: rotation changed bit count");
  end
endmodule

// File: rtl/dp_decode.sv
module dp_decode
  import dp_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dp_ctrl_t           ctrl_o
);
  logic [1:0]       class_bits;
  logic [OPC_W-1:0] opc_bits;
  logic             opc_known;
  logic [5:0]       unused_bits;

  assign class_bits  = instr_i[CLASS_LO +: 2];
  assign opc_bits    = instr_i[OPC_LO +: OPC_W];
  // condition field and flag-update bit carry no meaning in this stage
  assign unused_bits = {instr_i[31:28], instr_i[20], 1'b0};

  always_comb begin
    case (opc_bits)
      OPC_AND, OPC_SUB, OPC_RSB, OPC_COPY: opc_known = 1'b1;
      default:                             opc_known = 1'b0;
    endcase
  end

  always_comb begin
    ctrl_o.valid   = (class_bits == 2'b00) && opc_known;
    ctrl_o.opc     = dp_opc_e'(opc_bits);
    ctrl_o.use_imm = instr_i[IMMSEL_B];
    ctrl_o.rd      = instr_i[RD_LO +: REG_IDX_W];
    ctrl_o.rot     = instr_i[ROT_LO +: ROT_W];
    ctrl_o.imm_val = instr_i[IMM_VAL_W-1:0];
  end

  always_comb begin
    assert_class_gate_R1: assert (class_bits == 2'b00 || !ctrl_o.valid)
      else $error("R1: valid outside data-processing class");
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_exec_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  dp_opc_e      opc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  assign res_o = alu_eval(opc_i, a_i, b_i);

  always_comb begin
    assert_sub_inverse_R8: assert (opc_i != OPC_SUB || res_o + b_i == a_i)
      else $error("R8: subtract result inconsistent");
    assert_rsb_inverse_R9: assert (opc_i != OPC_RSB || res_o + a_i == b_i)
      else $error("R9: reverse subtract result inconsistent");
  end
endmodule

// File: rtl/dp_exec_stage.sv
module dp_exec_stage
  import dp_exec_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [31:0] rn_val_i,
  input  logic [31:0] rm_val_i,
  output logic [31:0] result_o,
  output logic [3:0]  rd_idx_o,
  output logic        wr_en_o
);
  dp_ctrl_t          ctrl;
  logic [DATA_W-1:0] imm_word;
  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] alu_res;

  dp_decode u_decode (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  dp_imm_expand u_imm (
    .val_i (ctrl.imm_val),
    .rot_i (ctrl.rot),
    .imm_o (imm_word)
  );

  assign op2 = ctrl.use_imm ? imm_word : rm_val_i;

  dp_alu u_alu (
    .opc_i (ctrl.opc),
    .a_i   (rn_val_i),
    .b_i   (op2),
    .res_o (alu_res)
  );

  assign wr_en_o  = ctrl.valid;
  assign rd_idx_o = ctrl.rd;
  assign result_o = ctrl.valid ? alu_res : '0;

  always_comb begin
    assert_copy_op2_R6: assert (!(wr_en_o && ctrl.opc == OPC_COPY) || result_o == op2)
      else $error("R6: copy result differs from operand");
    assert_idle_zero_R12: assert (wr_en_o || result_o == '0)
      else $error("R12: nonzero result without write");
    assert_reg_operand_R3: assert (ctrl.use_imm || op2 == rm_val_i)
      else $error("R3: register operand not selected");
  end
endmodule

// File: tb/dp_exec_stage_tb.sv
module dp_exec_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr, rn, rm;
  logic [31:0] result;
  logic [3:0]  rd_idx;
  logic        wr_en;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dp_exec_stage dut_i (
    .instr_i (instr), .rn_val_i (rn), .rm_val_i (rm),
    .result_o (result), .rd_idx_o (rd_idx), .wr_en_o (wr_en)
  );

  function automatic logic [31:0] model_imm(logic [11:0] f);
    logic [31:0] v = {24'h0, f[7:0]};
    for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
    return v;
  endfunction

  function automatic void model(logic [31:0] ins, logic [31:0] a, logic [31:0] m,
                                output logic [31:0] res, output logic we);
    logic [31:0] b = ins[25] ? model_imm(ins[11:0]) : m;
    we = 1'b1;
    res = 32'h0;
    if (ins[27:26] != 2'b00) we = 1'b0;
    else case (int'(ins[24:21]))
      13: res = b;
      0:  res = a & b;
      2:  res = a + ~b + 1;
      3:  res = b + ~a + 1;
      default: we = 1'b0;
    endcase
    if (!we) res = 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply at a falling edge, sample a quarter period after the next rising edge
  task automatic run(string tag, logic [31:0] ins, logic [31:0] a, logic [31:0] m);
    logic [31:0] er;
    logic        ew;
    @(negedge clk);
    instr = ins; rn = a; rm = m;
    @(posedge clk); #5;
    model(ins, a, m, er, ew);
    check({tag, " result"}, result, er);
    check({tag, " wr_en"}, {31'h0, wr_en}, {31'h0, ew});
    check({tag, " R10 rd"}, {28'h0, rd_idx}, {28'h0, ins[15:12]});
  endtask

  initial begin
    instr = 32'h0; rn = 32'h0; rm = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #5;
    check("reset-state R7 result", result, 32'h0);
    check("reset-state R1 wr_en", {31'h0, wr_en}, 32'h1);

    run("R6 copy imm 10", 32'he3a0200a, 32'h1234_5678, 32'h0);
    check("R6 copy imm value", result, 32'd10);
    run("R4 rot1 of ff", 32'he3a031ff, 32'h0, 32'h0);
    check("R4 rot1 value", result, 32'hc000_003f);
    run("R5 rot15 of 01", 32'he3a04f01, 32'h0, 32'h0);
    check("R5 rot15 value", result, 32'h0000_0004);
    run("R5 rot0 of a5", 32'he3a040a5, 32'h0, 32'h0);
    check("R5 rot0 value", result, 32'h0000_00a5);
    for (int r = 0; r < 16; r++)
      run("R4 rot sweep", 32'he3a05000 | (r << 8) | 32'h81, 32'h0, 32'h0);
    run("R3 reg operand copy", 32'he1a06003, 32'hffff_ffff, 32'hdead_beef);
    check("R3 copy reg value", result, 32'hdead_beef);
    run("R6 rn ignored a", 32'he1a06003, 32'h0, 32'h5555_aaaa);
    run("R6 rn ignored b", 32'he1a06003, 32'h7777_7777, 32'h5555_aaaa);
    run("R7 and reg", 32'he0012003, 32'hf0f0_ff00, 32'h3c3c_0ff0);
    run("R8 sub wrap", 32'he0412003, 32'h0, 32'h1);
    check("R8 wrap value", result, 32'hffff_ffff);
    run("R9 rsb imm", 32'he2612064, 32'd30, 32'h0);
    check("R9 rsb value", result, 32'd70);
    run("R8 sub imm", 32'he2412064, 32'd30, 32'h0);
    check("R8 sub imm value", result, 32'hffff_ffba);
    run("R11 S set sub", 32'he0512003, 32'h10, 32'h3);
    check("R11 S value", result, 32'hd);
    run("R1 class 01", 32'he5912003, 32'h10, 32'h3);
    check("R12 class idle zero", result, 32'h0);
    run("R2 opcode 0100", 32'he0812003, 32'h10, 32'h3);
    check("R2 unknown wr_en", {31'h0, wr_en}, 32'h0);
    run("R10 rd=15", 32'he3a0f0ff, 32'h0, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins = $urandom;
      if (i % 4 != 0) ins[27:26] = 2'b00;
      if (i % 3 == 0) ins[24:21] = 4'b1101;
      else if (i % 3 == 1) ins[24:21] = (i % 2) ? 4'b0010 : 4'b0011;
      run("R2 R3 R7 R8 R9 random", ins, $urandom, $urandom);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule